// File: doc/BRIEF.md
# Ethernet Test Frame Generator

This block produces complete Ethernet frames for link bring-up and error-rate testing. Once software sets its enable, it streams bytes on a byte-wide transmit port with a valid strobe and start/end-of-frame markers. Each frame has a preamble, a start delimiter, a destination and a source address, a 16-bit length field, a payload and a CRC-32 frame check sequence. The addresses, payload length, payload pattern, idle gap between frames and whether the check sequence is valid or deliberately corrupted all come from configuration inputs. These inputs are sampled once at the start of each frame.

A duration input picks one of two modes. In burst mode the generator sends a fixed number of frames and then clears its own enable. In continuous mode it runs until software clears the enable. A frame that is already on the wire when the enable drops is always finished. An optional gate output lets the surrounding logic silence the normal MAC receive path while the generator is running.

Top module: `eth_test_pktgen`

## Requirements
- R1: After reset, tx_valid, tx_sof, tx_eof, gen_en, busy and rx_blocked are all 0.
- R2: A frame is sent on consecutive cycles with tx_valid high throughout, in this order: seven 0x55 bytes, one 0xD5 byte, the six bytes of dst_addr (bits 47:40 first), the six bytes of src_addr (bits 47:40 first), a 16-bit length field (high byte first) that equals the payload byte count, the payload, and four check bytes. tx_sof is high only on the first 0x55 byte, and tx_eof is high only on the last check byte.
- R3: Payload byte p (counting from 0) depends on pat_mode, using pat_seed as s, with all arithmetic modulo 256: mode 0 gives s; mode 1 gives s+p; mode 2 gives s when p is even and ~s when p is odd; mode 3 gives s-p.
- R4: A payload_len of 0 is sent as a one-byte payload, and the length field then reads 1.
- R5: The check bytes hold the reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones, final inversion) computed over the bytes from the destination address through the last payload byte. They are sent least significant byte first. When bad_fcs is 1, all 32 check bits are inverted.
- R6: While enabled, exactly gap_len idle cycles separate the tx_eof cycle of one frame from the tx_sof cycle of the next. A gap_len of 0 gives back-to-back frames.
- R7: When the block is idle and en_set is sampled high, gen_en is high in the next cycle and tx_sof is high in the cycle after that.
- R8: If en_clr is sampled high in the middle of a frame, gen_en is low in the next cycle, the current frame still completes at full length, no further frame starts, and busy then returns to 0.
- R9: When en_set and en_clr are sampled high in the same cycle, en_clr wins and no frame starts.
- R10: With continuous at 0, exactly PKT_LIMIT frames are sent after en_set, and then gen_en and busy return to 0 without any software action.
- R11: With continuous at 1, frames keep being sent beyond PKT_LIMIT and gen_en stays high until en_clr is applied.
- R12: The address, length, gap, pattern and check-mode inputs are captured at frame start. Changing them during a frame does not alter that frame, and the change takes effect on the next frame.
- R13: rx_blocked equals block_rx while gen_en or busy is high, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_set | input | 1 | Pulse that sets the generator enable |
| en_clr | input | 1 | Pulse that clears the generator enable; takes priority over en_set |
| continuous | input | 1 | 1: run until cleared; 0: stop after PKT_LIMIT frames |
| bad_fcs | input | 1 | 1: send inverted check bytes |
| block_rx | input | 1 | Request to gate the MAC receive path while running |
| dst_addr | input | 48 | Destination address |
| src_addr | input | 48 | Source address |
| payload_len | input | LEN_W | Payload byte count (0 is sent as 1) |
| gap_len | input | GAP_W | Idle cycles between frames |
| pat_mode | input | 2 | Payload pattern select (see R3) |
| pat_seed | input | 8 | Payload pattern seed byte |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_data | output | 8 | Transmit byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| gen_en | output | 1 | Current state of the generator enable |
| busy | output | 1 | A frame or inter-frame gap is in progress |
| rx_blocked | output | 1 | Receive-path gate |

## Verification
Each frame is compared byte by byte against a frame the bench builds itself, including its own CRC-32. The payload is tried with a constant pattern, an incrementing pattern whose seed makes it wrap past 0xFF, an alternating pattern and a decrementing pattern; these separate an index that is applied in the wrong direction, a stuck index and a wrong odd/even parity. Three more cases test the boundaries: a zero payload length, gap values of 0 and 5, and an inverted check sequence. These show whether the length is clamped, whether the gap is off by one, and whether the check bytes are sent in the wrong byte order. Changing the destination address in the middle of a frame shows that the configuration is captured at frame start. Burst runs, continuous runs and a clear in the middle of a frame separate the automatic stop from the stop requested by software.

// File: rtl/pktgen_pkg.sv
package pktgen_pkg;

    typedef enum logic [1:0] {
        PAT_CONST = 2'd0,
        PAT_INCR  = 2'd1,
        PAT_ALT   = 2'd2,
        PAT_DECR  = 2'd3
    } pat_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_HDR  = 3'd1,
        SQ_PAY  = 3'd2,
        SQ_FCS  = 3'd3,
        SQ_GAP  = 3'd4
    } seq_st_e;

    localparam logic [7:0]  PREAMBLE_BYTE = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam logic [4:0]  HDR_SFD_IDX   = 5'd7;
    localparam logic [4:0]  HDR_LAST_IDX  = 5'd21;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

    // One byte of reflected CRC-32, least significant bit first
    function automatic logic [31:0] crc32_byte(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c;
        c = c_in ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/pktgen_payload.sv
module pktgen_payload
    import pktgen_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [7:0] seed,
    input  logic [7:0] idx,
    output logic [7:0] pay_byte
);

    always_comb begin
        case (pat_mode_e'(mode))
            PAT_CONST: pay_byte = seed;
            PAT_INCR:  pay_byte = seed + idx;
            PAT_ALT:   pay_byte = idx[0] ? ~seed : seed;
            PAT_DECR:  pay_byte = seed - idx;
            default:   pay_byte = seed;
        endcase
    end

endmodule

// File: rtl/pktgen_ctrl.sv
module pktgen_ctrl #(
    parameter int PKT_LIMIT = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic en_clr,
    input  logic continuous,
    input  logic frame_done,
    output logic enable_q,
    output logic enable_d
);

    localparam int CNT_W = $clog2(PKT_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PKT_LIMIT - 1);

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d = q;
        if (en_clr) begin
            d.en = 1'b0;
        end else if (en_set && !q.en) begin
            d.en  = 1'b1;
            d.cnt = '0;
        end else if (frame_done && q.en && !continuous) begin
            if (q.cnt == CNT_LAST) begin
                d.en  = 1'b0;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign enable_q = q.en;
    assign enable_d = d.en;

    // R9: a clear request always leaves the enable low
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !enable_q);

    // R10: the frame counter never reaches the limit value
    a_r10_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CNT_W'(PKT_LIMIT));

endmodule

// File: rtl/pktgen_seq.sv
module pktgen_seq
    import pktgen_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_now,
    input  logic             run_next,
    input  logic [47:0]      dst_addr,
    input  logic [47:0]      src_addr,
    input  logic [LEN_W-1:0] payload_len,
    input  logic [GAP_W-1:0] gap_len,
    input  logic [1:0]       pat_mode,
    input  logic [7:0]       pat_seed,
    input  logic             bad_fcs,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_sof,
    output logic             tx_eof,
    output logic             frame_done,
    output logic             busy
);

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    typedef struct packed {
        seq_st_e          st;
        logic [4:0]       hidx;
        logic [LEN_W-1:0] pcnt;
        logic [1:0]       fidx;
        logic [GAP_W-1:0] gcnt;
        logic [31:0]      crc;
        logic [47:0]      da;
        logic [47:0]      sa;
        logic [LEN_W-1:0] len;
        logic [GAP_W-1:0] gap;
        logic [1:0]       mode;
        logic [7:0]       seed;
        logic             bad;
    } seq_t;

    seq_t q, d;

    logic [7:0]  hdr_byte, pay_byte, out_byte;
    logic [15:0] len_field;
    logic [2:0]  da_sel, sa_sel;
    logic [31:0] fcs_word;
    logic        start;

    pktgen_payload u_payload (
        .mode     (q.mode),
        .seed     (q.seed),
        .idx      (8'(q.pcnt)),
        .pay_byte (pay_byte)
    );

    // Header byte selection by header index
    always_comb begin
        len_field = 16'(q.len);
        da_sel    = 3'(5'd13 - q.hidx);
        sa_sel    = 3'(5'd19 - q.hidx);
        if (q.hidx < HDR_SFD_IDX)       hdr_byte = PREAMBLE_BYTE;
        else if (q.hidx == HDR_SFD_IDX) hdr_byte = SFD_BYTE;
        else if (q.hidx <= 5'd13)       hdr_byte = q.da[{da_sel, 3'b000} +: 8];
        else if (q.hidx <= 5'd19)       hdr_byte = q.sa[{sa_sel, 3'b000} +: 8];
        else if (q.hidx == 5'd20)       hdr_byte = len_field[15:8];
        else                            hdr_byte = len_field[7:0];
    end

    assign fcs_word = q.bad ? q.crc : ~q.crc;

    always_comb begin
        d          = q;
        start      = 1'b0;
        frame_done = 1'b0;
        out_byte   = 8'h00;
        case (q.st)
            SQ_IDLE: start = run_now;
            SQ_HDR: begin
                out_byte = hdr_byte;
                if (q.hidx > HDR_SFD_IDX) d.crc = crc32_byte(q.crc, hdr_byte);
                if (q.hidx == HDR_LAST_IDX) begin
                    d.st   = SQ_PAY;
                    d.pcnt = '0;
                end else begin
                    d.hidx = q.hidx + 5'd1;
                end
            end
            SQ_PAY: begin
                out_byte = pay_byte;
                d.crc    = crc32_byte(q.crc, pay_byte);
                if (q.pcnt == q.len - LEN_ONE) begin
                    d.st   = SQ_FCS;
                    d.fidx = 2'd0;
                end else begin
                    d.pcnt = q.pcnt + LEN_ONE;
                end
            end
            SQ_FCS: begin
                out_byte = fcs_word[{q.fidx, 3'b000} +: 8];
                if (q.fidx == 2'd3) begin
                    frame_done = 1'b1;
                    if (q.gap == '0) begin
                        if (run_next) start = 1'b1;
                        else          d.st  = SQ_IDLE;
                    end else begin
                        d.st   = SQ_GAP;
                        d.gcnt = q.gap - GAP_W'(1);
                    end
                end else begin
                    d.fidx = q.fidx + 2'd1;
                end
            end
            SQ_GAP: begin
                if (q.gcnt == '0) begin
                    if (run_now) start = 1'b1;
                    else         d.st  = SQ_IDLE;
                end else begin
                    d.gcnt = q.gcnt - GAP_W'(1);
                end
            end
            default: d.st = SQ_IDLE;
        endcase
        if (start) begin
            d.st   = SQ_HDR;
            d.hidx = 5'd0;
            d.crc  = '1;
            d.da   = dst_addr;
            d.sa   = src_addr;
            d.len  = (payload_len == '0) ? LEN_ONE : payload_len;
            d.gap  = gap_len;
            d.mode = pat_mode;
            d.seed = pat_seed;
            d.bad  = bad_fcs;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_valid = (q.st == SQ_HDR) || (q.st == SQ_PAY) || (q.st == SQ_FCS);
    assign tx_data  = out_byte;
    assign tx_sof   = (q.st == SQ_HDR) && (q.hidx == 5'd0);
    assign tx_eof   = (q.st == SQ_FCS) && (q.fidx == 2'd3);
    assign busy     = (q.st != SQ_IDLE);

    // R2: no hole inside a frame and no second start before the end
    a_r2_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_eof) |=> (tx_valid && !tx_sof));

    // R2: a frame begins only after idle or right after an end
    a_r2_sof_clean: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof |-> $past(!tx_valid || tx_eof));

    // R6: a nonzero gap leaves the line idle right after the end
    a_r6_gap_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_eof && q.gap != '0) |=> !tx_valid);

endmodule

// File: rtl/eth_test_pktgen.sv
module eth_test_pktgen #(
    parameter int PKT_LIMIT = 30_000_000,
    parameter int LEN_W     = 16,
    parameter int GAP_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             continuous,
    input  logic             bad_fcs,
    input  logic             block_rx,
    input  logic [47:0]      dst_addr,
    input  logic [47:0]      src_addr,
    input  logic [LEN_W-1:0] payload_len,
    input  logic [GAP_W-1:0] gap_len,
    input  logic [1:0]       pat_mode,
    input  logic [7:0]       pat_seed,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_sof,
    output logic             tx_eof,
    output logic             gen_en,
    output logic             busy,
    output logic             rx_blocked
);

    logic enable_q, enable_d, frame_done;

    pktgen_ctrl #(.PKT_LIMIT(PKT_LIMIT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_set     (en_set),
        .en_clr     (en_clr),
        .continuous (continuous),
        .frame_done (frame_done),
        .enable_q   (enable_q),
        .enable_d   (enable_d)
    );

    pktgen_seq #(.LEN_W(LEN_W), .GAP_W(GAP_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_now     (enable_q),
        .run_next    (enable_d),
        .dst_addr    (dst_addr),
        .src_addr    (src_addr),
        .payload_len (payload_len),
        .gap_len     (gap_len),
        .pat_mode    (pat_mode),
        .pat_seed    (pat_seed),
        .bad_fcs     (bad_fcs),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_sof      (tx_sof),
        .tx_eof      (tx_eof),
        .frame_done  (frame_done),
        .busy        (busy)
    );

    assign gen_en     = enable_q;
    assign rx_blocked = block_rx && (enable_q || busy);

    // R7: a frame starts only with the enable set now or one cycle earlier
    a_r7_sof_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof |-> (gen_en || $past(gen_en)));

endmodule

// File: tb/eth_test_pktgen_test.sv
module eth_test_pktgen_test;

    localparam int LIMIT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_set = 1'b0, en_clr = 1'b0, continuous = 1'b1;
    logic        bad_fcs = 1'b0, block_rx = 1'b0;
    logic [47:0] dst_addr = 48'h0211_2233_4455;
    logic [47:0] src_addr = 48'h0A66_7788_99AB;
    logic [15:0] payload_len = 16'd10;
    logic [7:0]  gap_len = 8'd3;
    logic [1:0]  pat_mode = 2'd0;
    logic [7:0]  pat_seed = 8'hA5;
    logic        tx_valid, tx_sof, tx_eof, gen_en, busy, rx_blocked;
    logic [7:0]  tx_data;

    int checks = 0;
    int fails  = 0;

    logic [7:0] exp_b [0:127];
    logic [7:0] got_b [0:127];
    int         exp_n;

    always #2 clk = ~clk;

    eth_test_pktgen #(.PKT_LIMIT(LIMIT), .LEN_W(16), .GAP_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .continuous(continuous), .bad_fcs(bad_fcs), .block_rx(block_rx),
        .dst_addr(dst_addr), .src_addr(src_addr), .payload_len(payload_len),
        .gap_len(gap_len), .pat_mode(pat_mode), .pat_seed(pat_seed),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .gen_en(gen_en), .busy(busy), .rx_blocked(rx_blocked)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c;
        c = c_in ^ {24'h0, b};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return c;
    endfunction

    // Builds the expected frame from the requirement text (R2..R5)
    task automatic build_exp(input logic [47:0] da, input logic [47:0] sa, input int len_in,
                             input int mode, input logic [7:0] s, input bit bad);
        int len;
        logic [31:0] c;
        logic [7:0] p8;
        len = (len_in == 0) ? 1 : len_in;
        for (int i = 0; i < 7; i++) exp_b[i] = 8'h55;
        exp_b[7] = 8'hD5;
        for (int i = 0; i < 6; i++) exp_b[8 + i]  = da[47 - 8*i -: 8];
        for (int i = 0; i < 6; i++) exp_b[14 + i] = sa[47 - 8*i -: 8];
        exp_b[20] = 8'(len >> 8);
        exp_b[21] = 8'(len);
        for (int p = 0; p < len; p++) begin
            p8 = 8'(p);
            case (mode)
                1: exp_b[22 + p] = s + p8;
                2: exp_b[22 + p] = p8[0] ? ~s : s;
                3: exp_b[22 + p] = s - p8;
                default: exp_b[22 + p] = s;
            endcase
        end
        c = 32'hFFFF_FFFF;
        for (int i = 8; i < 22 + len; i++) c = crc_step(c, exp_b[i]);
        if (!bad) c = ~c;
        for (int i = 0; i < 4; i++) exp_b[22 + len + i] = c[8*i +: 8];
        exp_n = 26 + len;
    endtask

    // Collects one frame; starts at a negedge, ends at the negedge showing tx_eof
    task automatic grab(output int n);
        int w;
        n = 0;
        w = 0;
        while (!tx_sof && w < 3000) begin
            @(negedge clk);
            w++;
        end
        if (!tx_sof) return;
        forever begin
            got_b[n] = tx_data;
            n++;
            if (tx_eof || n >= 128) break;
            @(negedge clk);
            if (!tx_valid) break;
        end
    endtask

    task automatic cmp_frame(input string tag);
        int n, bad_i;
        grab(n);
        bad_i = -1;
        for (int i = 0; i < n && i < exp_n; i++) if (bad_i < 0 && got_b[i] !== exp_b[i]) bad_i = i;
        if (n != exp_n) chk(1'b0, {tag, " frame length"}, n, exp_n);
        else if (bad_i >= 0) chk(1'b0, {tag, " byte mismatch"}, int'(got_b[bad_i]), int'(exp_b[bad_i]));
        else chk(1'b1, tag, 0, 0);
    endtask

    task automatic pulse_set();
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
    endtask

    task automatic wait_idle();
        int w;
        w = 0;
        while ((busy || tx_valid) && w < 5000) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic stop_gen();
        en_clr = 1'b1;
        @(negedge clk);
        en_clr = 1'b0;
        wait_idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!tx_valid && !tx_sof && !tx_eof, "R1 tx strobes idle", int'(tx_valid), 0);
        chk(!gen_en && !busy && !rx_blocked, "R1 status idle", int'({gen_en, busy, rx_blocked}), 0);
    endtask

    task automatic t_basic();
        continuous = 1'b1; pat_mode = 2'd0; payload_len = 16'd10; gap_len = 8'd3; bad_fcs = 1'b0;
        build_exp(dst_addr, src_addr, 10, 0, pat_seed, 1'b0);
        pulse_set();
        chk(gen_en && !tx_sof, "R7 enable set, no frame yet", int'({gen_en, tx_sof}), 2);
        @(negedge clk);
        chk(tx_sof === 1'b1, "R7 sof one cycle after enable", int'(tx_sof), 1);
        cmp_frame("R2 R5 constant payload frame");
        stop_gen();
    endtask

    task automatic t_modes();
        pat_seed = 8'hF0; payload_len = 16'd20;
        for (int m = 1; m < 4; m++) begin
            pat_mode = 2'(m);
            build_exp(dst_addr, src_addr, 20, m, 8'hF0, 1'b0);
            pulse_set();
            cmp_frame($sformatf("R3 pattern mode %0d", m));
            stop_gen();
        end
        pat_mode = 2'd0; pat_seed = 8'hA5;
    endtask

    task automatic t_zero_len();
        payload_len = 16'd0;
        build_exp(dst_addr, src_addr, 0, 0, pat_seed, 1'b0);
        pulse_set();
        cmp_frame("R4 zero payload length");
        stop_gen();
        payload_len = 16'd10;
    endtask

    task automatic t_bad_fcs();
        bad_fcs = 1'b1;
        build_exp(dst_addr, src_addr, 10, 0, pat_seed, 1'b1);
        pulse_set();
        cmp_frame("R5 inverted check bytes");
        stop_gen();
        bad_fcs = 1'b0;
    endtask

    task automatic t_gap(input int g);
        int n, k;
        gap_len = 8'(g);
        pulse_set();
        grab(n);
        k = 0;
        @(negedge clk);
        while (!tx_sof && !tx_valid && k < 300) begin
            k++;
            @(negedge clk);
        end
        chk(tx_sof && k == g, $sformatf("R6 idle cycles with gap %0d", g), k, g);
        stop_gen();
        gap_len = 8'd3;
    endtask

    task automatic t_latch();
        logic [47:0] old_da, new_da;
        int w;
        old_da = dst_addr;
        new_da = 48'h0ACE_0000_BEEF;
        build_exp(old_da, src_addr, 10, 0, pat_seed, 1'b0);
        pulse_set();
        w = 0;
        while (!tx_sof && w < 100) begin
            @(negedge clk);
            w++;
        end
        dst_addr = new_da;
        cmp_frame("R12 change during frame ignored");
        build_exp(new_da, src_addr, 10, 0, pat_seed, 1'b0);
        @(negedge clk);
        cmp_frame("R12 change used by next frame");
        stop_gen();
        dst_addr = old_da;
    endtask

    task automatic t_mid_clear();
        int n, w, extra;
        block_rx = 1'b1;
        payload_len = 16'd30;
        pulse_set();
        w = 0;
        while (!tx_sof && w < 100) begin
            @(negedge clk);
            w++;
        end
        chk(rx_blocked === 1'b1, "R13 gate follows block_rx while running", int'(rx_blocked), 1);
        n = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (tx_valid) n++;
        end
        en_clr = 1'b1;
        @(negedge clk);
        en_clr = 1'b0;
        chk(!gen_en, "R8 enable low after clear", int'(gen_en), 0);
        if (tx_valid) n++;
        while (tx_valid && !tx_eof && n < 200) begin
            @(negedge clk);
            if (tx_valid) n++;
        end
        chk(n == 56, "R8 interrupted frame completes", n, 56);
        extra = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tx_sof) extra++;
        end
        chk(extra == 0 && !busy, "R8 no frame after clear", extra, 0);
        chk(rx_blocked === 1'b0, "R13 gate low when stopped", int'(rx_blocked), 0);
        block_rx = 1'b0;
        payload_len = 16'd10;
    endtask

    task automatic t_both();
        int v;
        en_set = 1'b1; en_clr = 1'b1;
        @(negedge clk);
        en_set = 1'b0; en_clr = 1'b0;
        chk(!gen_en, "R9 clear wins over set", int'(gen_en), 0);
        v = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tx_valid) v++;
        end
        chk(v == 0, "R9 no frame started", v, 0);
    endtask

    task automatic t_burst();
        int frames, w, late;
        continuous = 1'b0; gap_len = 8'd2; payload_len = 16'd4;
        pulse_set();
        frames = 0; w = 0;
        while ((gen_en || busy) && w < 3000) begin
            if (tx_sof) frames++;
            @(negedge clk);
            w++;
        end
        chk(frames == LIMIT, "R10 burst frame count", frames, LIMIT);
        late = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (tx_valid || gen_en) late++;
        end
        chk(late == 0, "R10 stays stopped after burst", late, 0);
        continuous = 1'b1; gap_len = 8'd3; payload_len = 16'd10;
    endtask

    task automatic t_cont();
        int frames, w;
        continuous = 1'b1; payload_len = 16'd4; gap_len = 8'd1;
        pulse_set();
        frames = 0; w = 0;
        while (frames < 3 * LIMIT + 1 && w < 3000) begin
            if (tx_sof) frames++;
            @(negedge clk);
            w++;
        end
        chk(frames == 3 * LIMIT + 1 && gen_en, "R11 continuous beyond limit", frames, 3 * LIMIT + 1);
        stop_gen();
        chk(!gen_en && !busy, "R11 stops on clear", int'({gen_en, busy}), 0);
        payload_len = 16'd10; gap_len = 8'd3;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_modes();
        t_zero_len();
        t_bad_fcs();
        t_gap(5);
        t_gap(0);
        t_latch();
        t_mid_clear();
        t_both();
        t_burst();
        t_cont();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule